// File: doc/BRIEF.md
# Truncating Integer-to-Float Pipeline

This block turns a signed 32-bit integer into an IEEE-754 single-precision number. It always rounds toward zero; it has no rounding-mode input at all. Each operation carries a predicate word, and only bit 0 of that word matters. When bit 0 is set, the operation's destination write and its exception-flag update are committed. When it is clear, both are suppressed. A destination tag rides along with the data so that the surrounding datapath knows which register to write.

The unit is a three-stage pipeline that accepts one operation per clock. The first stage takes the absolute value. The second counts leading zeros and normalises. The third drops the excess low bits, packs the float and registers the outputs. A per-operation mode bit selects a flags-only variant. In that mode the destination receives the exception flags the conversion would have raised, in place of the converted value, and no flag update is issued. The sticky status register that collects the flag updates is outside this block.

Top module: `i2f_rz_pipe`

## Requirements
- R1: The operand is read as a two's-complement 32-bit integer. The result is {sign, 8-bit exponent with bias 127, 23-bit fraction}. For example, 3 gives 0x40400000, 0xFFFFFFFF gives 0xBF800000 and 0xFFFFFFFD gives 0xC0400000.
- R2: Rounding is toward zero. Magnitude bits below the 24-bit significand are discarded, so 0x7FFFFFFF gives 0x4EFFFFFF and 0x01000001 gives 0x4B800000.
- R3: 0x80000000 gives 0xCF000000 with no flag, and 0 gives 0x00000000 with no flag.
- R4: An operation presented with `in_valid` high in cycle c produces its outputs in cycle c+3. A new operation may be issued every cycle, and cycles without an operation produce no write.
- R5: `out_tag` in the commit cycle equals the `in_tag` given at issue.
- R6: Only `in_guard[0]` matters. When it is 0, `out_wen` stays low and `out_flag_upd` stays zero for that operation, whatever the upper guard bits are. When it is 1, the operation commits.
- R7: `out_flag_upd` uses bit 0 = inexact, bit 1 = underflow, bit 2 = overflow, bit 3 = divide-by-zero and bit 4 = invalid. Only bit 0 can ever be set. It is set exactly when nonzero magnitude bits were discarded, and only together with `out_wen`.
- R8: With `in_flags_only` = 1, a committed operation writes {27'b0, flags} to `out_result`, using the bit layout of R7, and `out_flag_upd` stays zero.
- R9: While `rst_n` is low, `out_wen`, `out_flag_upd`, `out_result` and `out_tag` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An operation is issued this cycle |
| in_operand | input | 32 | Signed integer to convert |
| in_guard | input | 32 | Predicate word; bit 0 enables the commit |
| in_tag | input | 5 | Destination tag |
| in_flags_only | input | 1 | Return the flags instead of the converted value |
| out_result | output | 32 | Float result, or the flag word in flags-only mode |
| out_wen | output | 1 | Destination write enable |
| out_tag | output | 5 | Destination tag of the committed operation |
| out_flag_upd | output | 5 | Exception flags to be OR-ed into the status register |

## Verification
Because the unit accepts an operation every cycle, an operation that commits a result and inexact flag can leave the pipeline in the same cycle that the operation behind it enters suppressed by its guard or in flags-only mode. Back-to-back streams are therefore driven that interleave guard-off operations, flags-only operations with inexact operands, and ordinary conversions. In every cycle the scoreboard checks that the write enable, the tag and the flag update match the one operation that is due, and it expects silence when no committing operation is due.

// File: rtl/i2f_pkg.sv
package i2f_pkg;
  localparam int FLAG_W        = 5;
  localparam int FLG_INEXACT   = 0;
  localparam int FLG_UNDERFLOW = 1;
  localparam int FLG_OVERFLOW  = 2;
  localparam int FLG_DIVZERO   = 3;
  localparam int FLG_INVALID   = 4;

  typedef logic [FLAG_W-1:0] flags_t;

  // Magnitude of a two's-complement word; the most negative value maps to 2^(n-1).
  function automatic logic [63:0] abs64(input logic [63:0] v, input int w);
    logic [63:0] r;
    r = v[w-1] ? (~v + 64'd1) : v;
    for (int i = 0; i < 64; i++) if (i >= w) r[i] = 1'b0;
    return r;
  endfunction

  // Build a flag vector holding only the inexact bit.
  function automatic flags_t make_flags(input logic inexact);
    flags_t f;
    f = '0;
    f[FLG_INEXACT] = inexact;
    return f;
  endfunction
endpackage

// File: rtl/i2f_lzc.sv
module i2f_lzc #(
  parameter int W    = 32,
  parameter int LZ_W = $clog2(W + 1)
) (
  input  logic [W-1:0]    vec,
  output logic [LZ_W-1:0] count
);
  logic found;
  always_comb begin
    count = LZ_W'(W);
    found = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!found && vec[i]) begin
        count = LZ_W'(W - 1 - i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2f_mag_stage.sv
module i2f_mag_stage #(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_guard0,
  input  logic              in_fonly,
  input  logic [DATA_W-1:0] in_operand,
  input  logic [TAG_W-1:0]  in_tag,
  output logic              q_commit,
  output logic              q_fonly,
  output logic              q_sign,
  output logic [DATA_W-1:0] q_mag,
  output logic [TAG_W-1:0]  q_tag
);
  logic [DATA_W-1:0] mag_c;
  logic [63:0]       mag_wide;

  always_comb begin
    mag_wide = i2f_pkg::abs64(64'(signed'(in_operand)), DATA_W);
    mag_c    = mag_wide[DATA_W-1:0];
  end

  logic [63-DATA_W:0] unused_mag_hi;
  assign unused_mag_hi = mag_wide[63:DATA_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_commit <= 1'b0;
      q_fonly  <= 1'b0;
      q_sign   <= 1'b0;
      q_mag    <= '0;
      q_tag    <= '0;
    end else begin
      q_commit <= in_valid & in_guard0;
      q_fonly  <= in_fonly;
      q_sign   <= in_operand[DATA_W-1];
      q_mag    <= mag_c;
      q_tag    <= in_tag;
    end
  end
endmodule

// File: rtl/i2f_norm_stage.sv
module i2f_norm_stage #(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 5,
  parameter int LZ_W   = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              d_commit,
  input  logic              d_fonly,
  input  logic              d_sign,
  input  logic [DATA_W-1:0] d_mag,
  input  logic [TAG_W-1:0]  d_tag,
  output logic              q_commit,
  output logic              q_fonly,
  output logic              q_sign,
  output logic              q_zero,
  output logic [LZ_W-1:0]   q_lz,
  output logic [DATA_W-1:0] q_norm,
  output logic [TAG_W-1:0]  q_tag
);
  logic [LZ_W-1:0]   lz_c;
  logic [DATA_W-1:0] norm_c;

  i2f_lzc #(.W(DATA_W), .LZ_W(LZ_W)) u_lzc (.vec(d_mag), .count(lz_c));

  assign norm_c = d_mag << lz_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_commit <= 1'b0;
      q_fonly  <= 1'b0;
      q_sign   <= 1'b0;
      q_zero   <= 1'b1;
      q_lz     <= '0;
      q_norm   <= '0;
      q_tag    <= '0;
    end else begin
      q_commit <= d_commit;
      q_fonly  <= d_fonly;
      q_sign   <= d_sign;
      q_zero   <= (d_mag == '0);
      q_lz     <= lz_c;
      q_norm   <= norm_c;
      q_tag    <= d_tag;
    end
  end
endmodule

// File: rtl/i2f_pack_stage.sv
module i2f_pack_stage #(
  parameter int DATA_W = 32,
  parameter int EXP_W  = 8,
  parameter int MAN_W  = 23,
  parameter int TAG_W  = 5,
  parameter int LZ_W   = $clog2(DATA_W + 1),
  parameter int RES_W  = 1 + EXP_W + MAN_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       d_commit,
  input  logic                       d_fonly,
  input  logic                       d_sign,
  input  logic                       d_zero,
  input  logic [LZ_W-1:0]            d_lz,
  input  logic [DATA_W-1:0]          d_norm,
  input  logic [TAG_W-1:0]           d_tag,
  output logic                       inexact_raw,
  output logic [RES_W-1:0]           q_result,
  output logic                       q_wen,
  output logic                       q_fonly,
  output logic [TAG_W-1:0]           q_tag,
  output logic [i2f_pkg::FLAG_W-1:0] q_flag_upd
);
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_TOP = BIAS + DATA_W - 1;
  localparam int DROP_W  = DATA_W - 1 - MAN_W;

  logic [MAN_W-1:0]     man_c;
  logic [EXP_W-1:0]     exp_c;
  i2f_pkg::flags_t      flags_c;
  logic [RES_W-1:0]     packed_c;
  logic                 unused_lead;

  assign unused_lead = d_norm[DATA_W-1];

  generate
    if (DROP_W > 0) begin : g_drop
      assign man_c       = d_norm[DATA_W-2 -: MAN_W];
      assign inexact_raw = |d_norm[DROP_W-1:0];
    end else if (DROP_W == 0) begin : g_exact
      assign man_c       = d_norm[DATA_W-2:0];
      assign inexact_raw = 1'b0;
    end else begin : g_pad
      assign man_c       = {d_norm[DATA_W-2:0], {(-DROP_W){1'b0}}};
      assign inexact_raw = 1'b0;
    end
  endgenerate

  always_comb begin
    exp_c    = d_zero ? '0 : EXP_W'(EXP_TOP - int'(d_lz));
    flags_c  = i2f_pkg::make_flags(inexact_raw & ~d_zero);
    packed_c = d_zero ? '0 : {d_sign, exp_c, man_c};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_result   <= '0;
      q_wen      <= 1'b0;
      q_fonly    <= 1'b0;
      q_tag      <= '0;
      q_flag_upd <= '0;
    end else begin
      q_result   <= d_fonly ? RES_W'(flags_c) : packed_c;
      q_wen      <= d_commit;
      q_fonly    <= d_fonly;
      q_tag      <= d_tag;
      q_flag_upd <= (d_commit && !d_fonly) ? flags_c : '0;
    end
  end
endmodule

// File: rtl/i2f_rz_pipe.sv
module i2f_rz_pipe #(
  parameter int DATA_W = 32,
  parameter int EXP_W  = 8,
  parameter int MAN_W  = 23,
  parameter int TAG_W  = 5,
  parameter int GRD_W  = 32,
  parameter int LZ_W   = $clog2(DATA_W + 1),
  parameter int RES_W  = 1 + EXP_W + MAN_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [DATA_W-1:0]          in_operand,
  input  logic [GRD_W-1:0]           in_guard,
  input  logic [TAG_W-1:0]           in_tag,
  input  logic                       in_flags_only,
  output logic [RES_W-1:0]           out_result,
  output logic                       out_wen,
  output logic [TAG_W-1:0]           out_tag,
  output logic [i2f_pkg::FLAG_W-1:0] out_flag_upd
);
  logic [GRD_W-1:0] unused_guard;
  assign unused_guard = in_guard;

  // stage 1 -> 2
  logic              s1_commit, s1_fonly, s1_sign;
  logic [DATA_W-1:0] s1_mag;
  logic [TAG_W-1:0]  s1_tag;
  // stage 2 -> 3
  logic              s2_commit, s2_fonly, s2_sign, s2_zero;
  logic [LZ_W-1:0]   s2_lz;
  logic [DATA_W-1:0] s2_norm;
  logic [TAG_W-1:0]  s2_tag;
  // events brought out for the checker
  logic              s3_inexact_raw;
  logic              res_is_flags;

  i2f_mag_stage #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_mag (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_guard0(in_guard[0]), .in_fonly(in_flags_only),
    .in_operand(in_operand), .in_tag(in_tag),
    .q_commit(s1_commit), .q_fonly(s1_fonly), .q_sign(s1_sign),
    .q_mag(s1_mag), .q_tag(s1_tag)
  );

  i2f_norm_stage #(.DATA_W(DATA_W), .TAG_W(TAG_W), .LZ_W(LZ_W)) u_norm (
    .clk(clk), .rst_n(rst_n),
    .d_commit(s1_commit), .d_fonly(s1_fonly), .d_sign(s1_sign),
    .d_mag(s1_mag), .d_tag(s1_tag),
    .q_commit(s2_commit), .q_fonly(s2_fonly), .q_sign(s2_sign),
    .q_zero(s2_zero), .q_lz(s2_lz), .q_norm(s2_norm), .q_tag(s2_tag)
  );

  i2f_pack_stage #(.DATA_W(DATA_W), .EXP_W(EXP_W), .MAN_W(MAN_W),
                   .TAG_W(TAG_W), .LZ_W(LZ_W), .RES_W(RES_W)) u_pack (
    .clk(clk), .rst_n(rst_n),
    .d_commit(s2_commit), .d_fonly(s2_fonly), .d_sign(s2_sign),
    .d_zero(s2_zero), .d_lz(s2_lz), .d_norm(s2_norm), .d_tag(s2_tag),
    .inexact_raw(s3_inexact_raw),
    .q_result(out_result), .q_wen(out_wen), .q_fonly(res_is_flags),
    .q_tag(out_tag), .q_flag_upd(out_flag_upd)
  );
endmodule

// File: rtl/i2f_rz_pipe_chk.sv
module i2f_rz_pipe_chk #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int TAG_W = 5,
  parameter int RES_W = 1 + EXP_W + MAN_W
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic                       in_guard0,
  input logic [TAG_W-1:0]           in_tag,
  input logic [RES_W-1:0]           out_result,
  input logic                       out_wen,
  input logic [TAG_W-1:0]           out_tag,
  input logic [i2f_pkg::FLAG_W-1:0] out_flag_upd,
  input logic                       res_is_flags
);
  localparam int BIAS      = (1 << (EXP_W - 1)) - 1;
  localparam int MIN_INEXP = BIAS + MAN_W + 1;

  logic [1:0] since_rst;
  logic       warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end
  assign warm = (since_rst == 2'd3);

  // R4: the write enable follows the committed issue three cycles later
  a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (out_wen == $past(in_valid && in_guard0, 3)));

  // R5: the tag travels with its operation
  a_r5_tag_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && out_wen) |-> (out_tag == $past(in_tag, 3)));

  // R7: a flag update never appears without a write
  a_r7_flag_needs_wen: assert property (@(posedge clk) disable iff (!rst_n)
    (out_flag_upd != '0) |-> out_wen);

  // R7: only the inexact bit may be raised
  a_r7_only_inexact: assert property (@(posedge clk) disable iff (!rst_n)
    out_flag_upd[i2f_pkg::FLAG_W-1:1] == '0);

  // R2: truncation loses bits only for large magnitudes
  a_r2_inexact_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_flag_upd[i2f_pkg::FLG_INEXACT] |->
      (int'(out_result[RES_W-2 -: EXP_W]) >= MIN_INEXP));

  // R8: flags-only results carry no flag update and no high bits
  a_r8_flags_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (out_wen && res_is_flags) |->
      (out_flag_upd == '0 && out_result[RES_W-1:i2f_pkg::FLAG_W] == '0));

  // R9: quiet outputs during reset
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r9_reset_quiet: assert (out_wen == 1'b0 && out_flag_upd == '0);
    end
  end
endmodule

bind i2f_rz_pipe i2f_rz_pipe_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W), .TAG_W(TAG_W), .RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_guard0(in_guard[0]),
  .in_tag(in_tag), .out_result(out_result), .out_wen(out_wen),
  .out_tag(out_tag), .out_flag_upd(out_flag_upd), .res_is_flags(res_is_flags)
);

// File: tb/i2f_rz_pipe_test.sv
module i2f_rz_pipe_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_operand = '0;
  logic [31:0] in_guard = '0;
  logic [4:0]  in_tag = '0;
  logic        in_flags_only = 1'b0;
  logic [31:0] out_result;
  logic        out_wen;
  logic [4:0]  out_tag;
  logic [4:0]  out_flag_upd;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;

  typedef struct {
    int          due;
    logic        wen;
    logic [31:0] res;
    logic [4:0]  tag;
    logic [4:0]  flg;
    string       req;
  } item_t;
  item_t sb[$];

  i2f_rz_pipe uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_operand(in_operand),
    .in_guard(in_guard), .in_tag(in_tag), .in_flags_only(in_flags_only),
    .out_result(out_result), .out_wen(out_wen), .out_tag(out_tag),
    .out_flag_upd(out_flag_upd)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=0x%08h expected=0x%08h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // Reference: find the top set bit by scanning, keep 24 significant bits.
  function automatic logic [31:0] ref_conv(input logic [31:0] x, output logic inx);
    logic        s;
    logic [63:0] m, keep;
    int          hb;
    s   = x[31];
    m   = {32'd0, (s ? (32'd0 - x) : x)};
    inx = 1'b0;
    if (m == 0) return 32'd0;
    hb = 31;
    while (m[hb] == 1'b0) hb--;
    if (hb > 23) begin
      keep = m >> (hb - 23);
      inx  = ((m & ((64'd1 << (hb - 23)) - 1)) != 0);
    end else begin
      keep = m << (23 - hb);
    end
    return {s, 8'(127 + hb), keep[22:0]};
  endfunction

  task automatic issue(input logic [31:0] x, input logic [31:0] g, input logic [4:0] t,
                       input logic fo, input string req);
    item_t it;
    logic  inx;
    logic [31:0] r;
    @(negedge clk);
    in_valid = 1'b1; in_operand = x; in_guard = g; in_tag = t; in_flags_only = fo;
    r = ref_conv(x, inx);
    it.due = cyc + 3;
    it.wen = g[0];
    it.tag = t;
    it.req = req;
    if (fo) begin
      it.res = {27'd0, 4'd0, inx};
      it.flg = 5'd0;
    end else begin
      it.res = r;
      it.flg = g[0] ? {4'd0, inx} : 5'd0;
    end
    sb.push_back(it);
  endtask

  task automatic idle(input logic [31:0] junk);
    @(negedge clk);
    in_valid = 1'b0; in_operand = junk; in_guard = 32'hFFFF_FFFF; in_tag = junk[4:0];
  endtask

  // Monitor: pops the scoreboard at each due cycle, otherwise expects silence (R4).
  always @(negedge clk) begin
    if (mon_on) begin
      if (sb.size() != 0 && sb[0].due == cyc) begin
        item_t it;
        it = sb.pop_front();
        check(it.wen ? it.req : "R6", "wen", 32'(out_wen), 32'(it.wen));
        check(it.wen ? it.req : "R6", "flag_upd", 32'(out_flag_upd), 32'(it.flg));
        if (it.wen) begin
          check(it.req, "result", out_result, it.res);
          check("R5", "tag", 32'(out_tag), 32'(it.tag));
        end
      end else begin
        check("R4", "idle wen", 32'(out_wen), 32'd0);
        check("R4", "idle flag_upd", 32'(out_flag_upd), 32'd0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL R4 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", "reset wen", 32'(out_wen), 32'd0);
    check("R9", "reset flag_upd", 32'(out_flag_upd), 32'd0);
    check("R9", "reset result", out_result, 32'd0);
    check("R9", "reset tag", 32'(out_tag), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1'b1;

    // R1 basic values, back to back
    issue(32'd3,          32'd1, 5'd1, 1'b0, "R1");
    issue(32'hFFFF_FFFF,  32'd1, 5'd2, 1'b0, "R1");
    issue(32'hFFFF_FFFD,  32'd1, 5'd3, 1'b0, "R1");
    issue(32'h00FF_FFFF,  32'd1, 5'd4, 1'b0, "R1");
    // R2 truncation
    issue(32'h7FFF_FFFF,  32'd1, 5'd5, 1'b0, "R2");
    issue(32'h0100_0001,  32'd1, 5'd6, 1'b0, "R2");
    issue(32'h7FFF_FFF1,  32'd1, 5'd7, 1'b0, "R2");
    issue(32'h8123_4567,  32'd1, 5'd8, 1'b0, "R2");
    // R3 extremes
    issue(32'h8000_0000,  32'd1, 5'd9, 1'b0, "R3");
    issue(32'd0,          32'd1, 5'd10, 1'b0, "R3");
    idle(32'h7FFF_FFFF);
    idle(32'h1234_5678);
    // R6 guard: only bit 0 matters; inexact operands behind a false guard
    issue(32'h7FFF_FFFF,  32'hFFFF_FFFE, 5'd11, 1'b0, "R6");
    issue(32'h7FFF_FFFF,  32'h0000_0003, 5'd12, 1'b0, "R6");
    issue(32'hFFFF_FFFD,  32'h0000_0000, 5'd13, 1'b0, "R6");
    issue(32'h8000_0001,  32'h8000_0001, 5'd14, 1'b0, "R6");
    // R8 flags-only, mixed with R7 conversions in the same stream
    issue(32'h7FFF_FFFF,  32'd1, 5'd15, 1'b1, "R8");
    issue(32'h7FFF_FFFF,  32'd1, 5'd16, 1'b0, "R7");
    issue(32'd3,          32'd1, 5'd17, 1'b1, "R8");
    issue(32'h7FFF_FFFF,  32'd0, 5'd18, 1'b1, "R8");
    issue(32'h0100_0001,  32'd1, 5'd19, 1'b0, "R7");
    idle(32'd0);
    // pseudo-random stream with varied guard and mode
    lfsr = 32'hACE1_2468;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (lfsr[7:5] == 3'd0) idle(lfsr);
      else issue(lfsr >> lfsr[12:8], {31'd0, lfsr[3] | lfsr[4]}, lfsr[20:16],
                 (lfsr[11:9] == 3'd0), "R1");
    end
    repeat (8) idle(32'd0);
    check("R4", "scoreboard drained", 32'(sb.size()), 32'd0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule